// File: doc/BRIEF.md
# MAC Address Hash Filter Lookup

This block decides whether a 48-bit destination MAC address is present in an address filter table. The table holds 2048 entries of two 32-bit words in an internal RAM and uses open addressing. A lookup turns the address into an 11-bit home index with a fixed hash. It then probes entries one by one from that index until it finds a matching entry, reaches an empty entry, or runs out of hops. The index wraps from the last entry back to entry 0. On a match the block returns two attribute flags stored in the entry. A host write port lets software place fully formed entries at any index. Frame parsing and the fetch of table contents from external memory are handled elsewhere.

The control is one state machine with four named states:

- `ST_CLEAR` sweeps zeros through the whole table after reset.
- `ST_IDLE` accepts a lookup and issues the read of the home entry.
- `ST_PROBE` evaluates one entry per clock.
- `ST_REPORT` presents the result for one cycle.

The transitions are:

- CLEAR→IDLE when the sweep writes the last entry.
- IDLE→PROBE on an accepted start.
- PROBE→PROBE on a valid entry that does not match while hops remain.
- PROBE→REPORT on an empty entry, a match, or the final hop.
- REPORT→IDLE always.

Top module: `mac_hash_filter`

## Requirements
- R1: After reset the block writes zero to all 2048 entries. `lk_ready` stays low for exactly 2048 cycles and then rises. Host writes issued during this clearing are ignored, so a later lookup of that address misses.
- R2: The home index is computed as follows. Let H be `lk_mac[47:32]` and L be `lk_mac[31:0]`, with the bits of every byte of each reversed. Define f0 = L[7:2], f1 = {L[14:8],L[1:0]}, f2 = L[23:15] and f3 = {H[0],L[31:24]}. The index is the low 11 bits of {f0, f1^f2^f3}.
- R3: An entry's high word is formed from the low part l as follows: l[7:4] at bits 18:15, l[3:0] at 14:11, l[15:12] at 10:7, l[11:8] at 6:3, l[23:21] at 2:0, and zero elsewhere. Its low word is formed from the high part m and from l as follows: l[20] at bit 31, l[19:16] at 30:27, l[31:28] at 26:23, l[27:24] at 22:19, m[7:4] at 18:15, m[3:0] at 14:11, m[15:12] at 10:7, m[11:8] at 6:3.
- R4: In the low word, bit 0 is valid, bit 1 is skip and bit 2 is discard. A match needs equal high words and equal low words with bits 2:0 ignored.
- R5: One entry is probed per clock, starting at the home index and stepping by one. `lk_done` rises exactly P+1 cycles after the start was sampled, where P is the number of entries probed.
- R6: Probing continues from entry 2047 to entry 0.
- R7: An entry with its valid bit clear ends the lookup as a miss, with `lk_discard` and `lk_skip` low.
- R8: After HOPS entries are probed without a match or an empty entry (default 12), the lookup ends as a miss. An entry further on is never reached.
- R9: A match with skip clear gives `lk_hit`=1 and `lk_discard` equal to the entry's discard bit. A match with skip set gives `lk_hit`=0, `lk_skip`=1 and `lk_discard`=0.
- R10: `lk_done` is a one-cycle pulse, and the result outputs are valid only with it. A start is accepted only while `lk_ready` is high and is ignored otherwise. `lk_ready` returns the cycle after `lk_done`.
- R11: A host write and a probe read of the same entry can fall in the same cycle. In that case the probe sees the entry's previous content, and the written content is seen by later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_start | input | 1 | Start a lookup (sampled while ready) |
| lk_mac | input | 48 | Destination address, first byte in bits 47:40 |
| lk_ready | output | 1 | Block idle and able to accept a start |
| lk_done | output | 1 | One-cycle result strobe |
| lk_hit | output | 1 | Address accepted by the filter |
| lk_discard | output | 1 | Discard attribute of the hit entry |
| lk_skip | output | 1 | Matching entry carried the skip flag |
| hw_en | input | 1 | Host entry write strobe |
| hw_index | input | 11 | Host write entry index |
| hw_hi | input | 32 | Host write high word |
| hw_lo | input | 32 | Host write low word |

## Verification
A host write and a probe read can target the same RAM entry in the same clock. The bench provokes this by raising `lk_start` and `hw_en` on the same edge, with the write aimed at the home index of the address being looked up. It judges the outcome by requiring a miss with a two-cycle latency, since the probe sees the old empty entry. An immediate second lookup must then hit. A host write during the post-reset clear is a second overlap, and it is judged by a later miss on that address.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    localparam int IDX_W  = 11;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int WORD_W = 32;

    localparam int FLAG_VALID = 0;
    localparam int FLAG_SKIP  = 1;
    localparam int FLAG_DISC  = 2;

    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } entry_t;

    typedef enum logic [1:0] {
        ST_CLEAR  = 2'd0,
        ST_IDLE   = 2'd1,
        ST_PROBE  = 2'd2,
        ST_REPORT = 2'd3
    } state_t;
endpackage

// File: rtl/mhf_hash.sv
module mhf_hash
    import mhf_pkg::*;
(
    input  logic [47:0] mac,
    output idx_t        home_idx,
    output entry_t      key
);
    localparam int NBYTES = 6;

    logic [47:0] rev;
    logic [15:0] m;
    logic [31:0] l;
    logic [15:0] rh;
    logic [31:0] rl;
    logic [5:0]  f0;
    logic [8:0]  f1, f2, f3, fx;

    // reverse the bit order inside every byte
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign rev[b*8 + i] = mac[b*8 + 7 - i];
        end
    end

    assign rh = rev[47:32];
    assign rl = rev[31:0];
    assign f0 = rl[7:2];
    assign f1 = {rl[14:8], rl[1:0]};
    assign f2 = rl[23:15];
    assign f3 = {rh[0], rl[31:24]};
    assign fx = f1 ^ f2 ^ f3;
    assign home_idx = {f0[1:0], fx};

    assign m = mac[47:32];
    assign l = mac[31:0];

    always_comb begin
        key = '0;
        key.hi[18:15] = l[7:4];
        key.hi[14:11] = l[3:0];
        key.hi[10:7]  = l[15:12];
        key.hi[6:3]   = l[11:8];
        key.hi[2:0]   = l[23:21];
        key.lo[31]    = l[20];
        key.lo[30:27] = l[19:16];
        key.lo[26:23] = l[31:28];
        key.lo[22:19] = l[27:24];
        key.lo[18:15] = m[7:4];
        key.lo[14:11] = m[3:0];
        key.lo[10:7]  = m[15:12];
        key.lo[6:3]   = m[11:8];
    end
endmodule

// File: rtl/mhf_table.sv
module mhf_table
    import mhf_pkg::*;
(
    input  logic   clk,
    input  logic   we,
    input  idx_t   waddr,
    input  entry_t wdata,
    input  idx_t   raddr,
    output entry_t rdata
);
    entry_t mem [DEPTH];

    // read-first: a same-cycle write is not visible to this read
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/mhf_fsm.sv
module mhf_fsm
    import mhf_pkg::*;
#(
    parameter int HOPS = 12
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  idx_t   home_idx,
    input  entry_t key_in,
    input  entry_t q,
    output idx_t   rd_idx,
    output logic   clr_en,
    output idx_t   clr_idx,
    output logic   ready,
    output logic   done,
    output logic   hit,
    output logic   discard,
    output logic   skip
);
    localparam int HOP_W = $clog2(HOPS + 1);

    state_t           state, state_nx;
    idx_t             cur_idx, sweep;
    logic [HOP_W-1:0] hop, hop_nx;
    entry_t           key_q;
    logic             r_hit, r_disc, r_skip;
    logic             n_hit, n_disc, n_skip;
    logic             ent_valid, ent_match;

    assign ent_valid = q.lo[FLAG_VALID];
    assign ent_match = (q.hi == key_q.hi) && (q.lo[31:3] == key_q.lo[31:3]);

    always_comb begin
        state_nx = state;
        hop_nx   = hop;
        n_hit    = r_hit;
        n_disc   = r_disc;
        n_skip   = r_skip;
        rd_idx   = cur_idx;
        unique case (state)
            ST_CLEAR: begin
                if (sweep == idx_t'(DEPTH - 1)) state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                rd_idx = home_idx;
                if (start) begin
                    state_nx = ST_PROBE;
                    hop_nx   = '0;
                end
            end
            ST_PROBE: begin
                rd_idx = cur_idx + idx_t'(1);
                if (!ent_valid) begin
                    state_nx = ST_REPORT;
                    n_hit = 1'b0; n_disc = 1'b0; n_skip = 1'b0;
                end else if (ent_match) begin
                    state_nx = ST_REPORT;
                    n_hit  = ~q.lo[FLAG_SKIP];
                    n_skip =  q.lo[FLAG_SKIP];
                    n_disc =  q.lo[FLAG_DISC] & ~q.lo[FLAG_SKIP];
                end else if (hop == HOP_W'(HOPS - 1)) begin
                    state_nx = ST_REPORT;
                    n_hit = 1'b0; n_disc = 1'b0; n_skip = 1'b0;
                end else begin
                    hop_nx = hop + HOP_W'(1);
                end
            end
            ST_REPORT: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CLEAR;
            sweep   <= '0;
            cur_idx <= '0;
            hop     <= '0;
            key_q   <= '0;
            r_hit   <= 1'b0;
            r_disc  <= 1'b0;
            r_skip  <= 1'b0;
        end else begin
            state  <= state_nx;
            hop    <= hop_nx;
            r_hit  <= n_hit;
            r_disc <= n_disc;
            r_skip <= n_skip;
            if (state == ST_CLEAR) sweep <= sweep + idx_t'(1);
            if (state == ST_IDLE || state == ST_PROBE) cur_idx <= rd_idx;
            if (state == ST_IDLE && start) key_q <= key_in;
        end
    end

    always_comb begin
        clr_en  = (state == ST_CLEAR);
        clr_idx = sweep;
        ready   = (state == ST_IDLE);
        done    = (state == ST_REPORT);
        hit     = done & r_hit;
        discard = done & r_disc;
        skip    = done & r_skip;
    end
endmodule

// File: rtl/mac_hash_filter.sv
module mac_hash_filter
    import mhf_pkg::*;
#(
    parameter int HOPS = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_start,
    input  logic [47:0] lk_mac,
    output logic        lk_ready,
    output logic        lk_done,
    output logic        lk_hit,
    output logic        lk_discard,
    output logic        lk_skip,
    input  logic        hw_en,
    input  logic [10:0] hw_index,
    input  logic [31:0] hw_hi,
    input  logic [31:0] hw_lo
);
    idx_t   home_idx, rd_idx, clr_idx, waddr;
    entry_t key, q, wdata;
    logic   clr_en, we;

    mhf_hash u_hash (
        .mac      (lk_mac),
        .home_idx (home_idx),
        .key      (key)
    );

    mhf_fsm #(.HOPS(HOPS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (lk_start),
        .home_idx (home_idx),
        .key_in   (key),
        .q        (q),
        .rd_idx   (rd_idx),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .ready    (lk_ready),
        .done     (lk_done),
        .hit      (lk_hit),
        .discard  (lk_discard),
        .skip     (lk_skip)
    );

    // clearing owns the write port; host writes are dropped meanwhile
    always_comb begin
        if (clr_en) begin
            we    = 1'b1;
            waddr = clr_idx;
            wdata = '0;
        end else begin
            we       = hw_en;
            waddr    = hw_index;
            wdata.hi = hw_hi;
            wdata.lo = hw_lo;
        end
    end

    mhf_table u_table (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (rd_idx),
        .rdata (q)
    );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
    parameter int HOPS  = 12,
    parameter int DEPTH = 2048
) (
    input logic clk,
    input logic rst_n,
    input logic lk_start,
    input logic lk_ready,
    input logic lk_done,
    input logic lk_hit,
    input logic lk_skip,
    input logic lk_discard
);
    localparam int CW = $clog2(DEPTH + 2) + 1;
    localparam int BW = $clog2(HOPS + 3) + 1;

    logic [CW-1:0] since_rst;
    logic [BW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            busy_cnt  <= '0;
        end else begin
            if (since_rst < CW'(DEPTH + 1)) since_rst <= since_rst + CW'(1);
            if (lk_start && lk_ready)  busy_cnt <= BW'(1);
            else if (lk_done)          busy_cnt <= '0;
            else if (busy_cnt != '0)   busy_cnt <= busy_cnt + BW'(1);
        end
    end

    p_clear_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_ready |-> (since_rst >= CW'(DEPTH)));

    p_hop_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= BW'(HOPS + 1));

    p_skip_not_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_skip) |-> (!lk_hit && !lk_discard));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |=> !lk_done);

    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_start && lk_ready) |=> !lk_ready);

    p_ready_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |=> lk_ready);
endmodule

bind mac_hash_filter mhf_checker #(.HOPS(HOPS), .DEPTH(mhf_pkg::DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_start   (lk_start),
    .lk_ready   (lk_ready),
    .lk_done    (lk_done),
    .lk_hit     (lk_hit),
    .lk_skip    (lk_skip),
    .lk_discard (lk_discard)
);

// File: tb/test_mac_hash_filter.sv
module test_mac_hash_filter;
    localparam int HOPS = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_start = 1'b0;
    logic [47:0] lk_mac = '0;
    logic        lk_ready, lk_done, lk_hit, lk_discard, lk_skip;
    logic        hw_en = 1'b0;
    logic [10:0] hw_index = '0;
    logic [31:0] hw_hi = '0;
    logic [31:0] hw_lo = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mac_hash_filter #(.HOPS(HOPS)) i_mac_hash_filter (
        .clk(clk), .rst_n(rst_n), .lk_start(lk_start), .lk_mac(lk_mac),
        .lk_ready(lk_ready), .lk_done(lk_done), .lk_hit(lk_hit),
        .lk_discard(lk_discard), .lk_skip(lk_skip), .hw_en(hw_en),
        .hw_index(hw_index), .hw_hi(hw_hi), .hw_lo(hw_lo)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bhash(input logic [47:0] mac);
        logic [47:0] r;
        logic [5:0] a;
        logic [8:0] x;
        for (int k = 0; k < 48; k++) r[k] = mac[(k/8)*8 + 7 - (k%8)];
        a = r[7:2];
        x = {r[14:8], r[1:0]} ^ r[23:15] ^ {r[32], r[31:24]};
        return int'({a[1:0], x});
    endfunction

    function automatic logic [63:0] benc(input logic [47:0] mac, input logic [2:0] fl);
        logic [31:0] hi, lo;
        logic [15:0] m;
        logic [31:0] l;
        m = mac[47:32];
        l = mac[31:0];
        hi = {13'd0, l[7:4], l[3:0], l[15:12], l[11:8], l[23:21]};
        lo = {l[20], l[19:16], l[31:28], l[27:24], m[7:4], m[3:0], m[15:12], m[11:8], fl};
        return {hi, lo};
    endfunction

    function automatic logic [47:0] find_mac(input int want, input logic [47:0] seed);
        for (int i = 0; i < 200000; i++) begin
            logic [47:0] c;
            c = seed + 48'(i) * 48'h0000_0101_0203;
            if (bhash(c) == want) return c;
        end
        return seed;
    endfunction

    task automatic host_wr(input int idx, input logic [63:0] e);
        @(negedge clk);
        hw_en = 1'b1; hw_index = 11'(idx); hw_hi = e[63:32]; hw_lo = e[31:0];
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic lookup(input logic [47:0] mac, output logic h, output logic d,
                          output logic s, output int lat);
        @(negedge clk);
        lk_start = 1'b1; lk_mac = mac;
        lat = 0;
        @(negedge clk);
        lk_start = 1'b0;
        lat = 1;
        while (!lk_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        h = lk_hit; d = lk_discard; s = lk_skip;
    endtask

    // R1: clearing length and host writes ignored while clearing
    task automatic t_clear();
        logic [47:0] m0;
        int n;
        logic h, d, s;
        int lat;
        m0 = find_mac(0, 48'h02AA_1234_5678);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        @(negedge clk); n++;
        check("R1 ready low after reset", lk_ready, 0);
        check("R1 done low after reset", lk_done, 0);
        repeat (100) begin @(negedge clk); n++; end
        hw_en = 1'b1; hw_index = 11'd0;
        hw_hi = benc(m0, 3'b001) >> 32; hw_lo = benc(m0, 3'b001);
        @(negedge clk); n++;
        hw_en = 1'b0;
        while (!lk_ready && n < 5000) begin @(negedge clk); n++; end
        check("R1 clear cycles", n, 2048);
        lookup(m0, h, d, s, lat);
        check("R1 write during clear dropped (hit)", h, 0);
        check("R1 write during clear dropped (lat)", lat, 2);
    endtask

    // R2 R3 R5: direct hit at the home index
    task automatic t_basic();
        logic [47:0] a;
        logic h, d, s;
        int lat;
        a = find_mac(100, 48'h0011_2233_4455);
        host_wr(100, benc(a, 3'b001));
        lookup(a, h, d, s, lat);
        check("R2 hit at home index", h, 1);
        check("R5 one probe latency", lat, 2);
        check("R3 discard clear", d, 0);
    endtask

    // R4 R7 R9: flag bits ignored in compare, empty entry ends search
    task automatic t_flags();
        logic [47:0] b, b2;
        logic h, d, s;
        int lat;
        b  = find_mac(300, 48'h1234_5600_0001);
        b2 = find_mac(300, b + 48'h1);
        host_wr(300, benc(b, 3'b101));
        lookup(b, h, d, s, lat);
        check("R4 match ignores flag bits", h, 1);
        check("R9 discard returned", d, 1);
        lookup(b2, h, d, s, lat);
        check("R7 miss on empty next entry", h, 0);
        check("R7 two probes", lat, 3);
        check("R7 discard low on miss", d, 0);
    endtask

    // R9: skip flag makes a miss
    task automatic t_skip();
        logic [47:0] c;
        logic h, d, s;
        int lat;
        c = find_mac(500, 48'hA0B0_C0D0_E0F0);
        host_wr(500, benc(c, 3'b111));
        lookup(c, h, d, s, lat);
        check("R9 skip gives no hit", h, 0);
        check("R9 skip reported", s, 1);
        check("R9 discard masked", d, 0);
        check("R9 latency", lat, 2);
    endtask

    // R5: collision resolved on the next entry
    task automatic t_chain();
        logic [47:0] dm;
        logic h, d, s;
        int lat;
        dm = find_mac(700, 48'h5555_0000_1111);
        host_wr(700, benc(dm ^ 48'h1, 3'b001));
        host_wr(701, benc(dm, 3'b001));
        lookup(dm, h, d, s, lat);
        check("R5 hit on second probe", h, 1);
        check("R5 second probe latency", lat, 3);
    endtask

    // R8: hop limit
    task automatic t_hops();
        logic [47:0] f;
        logic h, d, s;
        int lat;
        f = find_mac(900, 48'h7777_1357_9BDF);
        for (int i = 0; i < HOPS; i++) host_wr(900 + i, benc(f ^ 48'(i + 1), 3'b001));
        host_wr(900 + HOPS, benc(f, 3'b001));
        lookup(f, h, d, s, lat);
        check("R8 miss after hop limit", h, 0);
        check("R8 latency hops+1", lat, HOPS + 1);
    endtask

    // R6: wrap from last entry
    task automatic t_wrap();
        logic [47:0] g;
        logic h, d, s;
        int lat;
        g = find_mac(2047, 48'h3C3C_0F0F_A5A5);
        host_wr(2047, benc(g ^ 48'h8000_0000_0000, 3'b001));
        host_wr(0, benc(g, 3'b001));
        lookup(g, h, d, s, lat);
        check("R6 hit after wrap", h, 1);
        check("R6 wrap latency", lat, 3);
    endtask

    // R11: write and probe of the same entry in one cycle
    task automatic t_overlap();
        logic [47:0] k;
        logic [63:0] e;
        logic h, d, s;
        int lat;
        k = find_mac(1200, 48'h0246_8ACE_1357);
        e = benc(k, 3'b001);
        @(negedge clk);
        lk_start = 1'b1; lk_mac = k;
        hw_en = 1'b1; hw_index = 11'd1200; hw_hi = e[63:32]; hw_lo = e[31:0];
        @(negedge clk);
        lk_start = 1'b0; hw_en = 1'b0;
        lat = 1;
        while (!lk_done && lat < 40) begin @(negedge clk); lat++; end
        check("R11 probe sees old entry", lk_hit, 0);
        check("R11 overlap latency", lat, 2);
        lookup(k, h, d, s, lat);
        check("R11 write landed", h, 1);
    endtask

    // R10: done pulse, start ignored while busy
    task automatic t_handshake();
        logic [47:0] a, other;
        int lat;
        a = find_mac(100, 48'h0011_2233_4455);
        other = find_mac(1500, 48'hFEED_0000_0001);
        @(negedge clk);
        lk_start = 1'b1; lk_mac = a;
        @(negedge clk);
        lk_mac = other;
        check("R10 busy after accept", lk_ready, 0);
        @(negedge clk);
        lk_start = 1'b0;
        check("R10 done at probe+1", lk_done, 1);
        check("R10 result is first lookup", lk_hit, 1);
        @(negedge clk);
        check("R10 done one cycle", lk_done, 0);
        check("R10 ready after done", lk_ready, 1);
        lat = 0;
        repeat (5) begin @(negedge clk); if (lk_done) lat++; end
        check("R10 ignored start gave no result", lat, 0);
    endtask

    initial begin
        t_clear();
        t_basic();
        t_flags();
        t_skip();
        t_chain();
        t_hops();
        t_wrap();
        t_overlap();
        t_handshake();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(64'd20 * 64'd190000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule